// File: doc/BRIEF.md
# Priority Interrupt Router with Overflow

This block gathers interrupt requests from a parameterised set of request nodes and offers exactly one of them to a single CPU. Each node keeps a pending flag, an enable bit, a programmable priority number and a sticky overflow flag. When a request is raised, withdrawn or accepted, an arbitration round runs over the nodes that take part. The winner's node index and priority number are then shown to the CPU together with a valid flag.

The CPU side gives its current priority number and an acknowledge pulse. The offered request may be taken only when its priority is at least the CPU's current level. Otherwise it stays pending and is offered again as soon as the CPU level drops. A hardware trigger that reaches a node whose earlier request is still pending is not queued. It sets the node's overflow flag and is dropped. A small write port lets software configure priority and enable, raise or withdraw a pending request, and clear overflow flags.

Top module: `irq_prio_router`

## Requirements
- R1: After reset no request is offered (`req_valid_o`=0), all pending and overflow flags are 0, and every node has priority 0 and is disabled. A node with priority 0 never wins, even when it is pending and enabled.
- R2: Only nodes that are pending, enabled and have a nonzero priority take part in arbitration. The winner is the one with the largest priority number. On equal numbers the lowest node index wins. When no node takes part, `req_valid_o` stays 0.
- R3: A round starts in any cycle with a trigger that newly sets a pending flag, a write, or an accepted acknowledge. `req_valid_o` is 0 in the following cycle, and the new result is shown in the cycle after that.
- R4: `take_ok_o` is 1 exactly when `req_valid_o` is 1 and `req_prio_o` >= `cpu_prio_i`. It follows `cpu_prio_i` in the same cycle.
- R5: When `ack_i` is high and `take_ok_o` is 1, the pending flag of the offered node clears at the next edge. An `ack_i` with `take_ok_o` at 0 changes nothing.
- R6: A trigger on a node that is already pending, and that is not being cleared in the same cycle, sets that node's overflow flag. It leaves the pending flag at 1 and starts no round.
- R7: An overflow flag stays set until a clear-overflow write to that node. A later trigger, a pending clear or the passing of time does not reset it.
- R8: Write commands on `wr_cmd_i`: 0 loads `wr_prio_i` and `wr_ena_i` into node `wr_node_i`; 1 sets its pending flag; 2 clears its pending flag; 3 clears its overflow flag. A software set never sets the overflow flag.
- R9: A trigger in the same cycle as a clear of the same node, whether a command-2 write or an accepted acknowledge, leaves the node pending and its overflow flag unchanged.
- R10: While no round is running and no event arrives, the offered valid flag, node and priority hold their values from cycle to cycle, whatever `cpu_prio_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | N_NODES | Single-cycle hardware trigger per node |
| wr_en_i | input | 1 | Write strobe |
| wr_node_i | input | IDX_W | Node addressed by the write |
| wr_cmd_i | input | 2 | Write command (see R8) |
| wr_prio_i | input | PRIO_W | Priority for command 0 |
| wr_ena_i | input | 1 | Enable for command 0 |
| cpu_prio_i | input | PRIO_W | Current CPU priority number |
| ack_i | input | 1 | CPU accepts the offered request |
| req_valid_o | output | 1 | A winner is offered |
| req_prio_o | output | PRIO_W | Priority number of the winner |
| req_node_o | output | IDX_W | Index of the winning node |
| take_ok_o | output | 1 | Offered winner may be taken at the current CPU level |
| pend_o | output | N_NODES | Pending flag per node |
| ovf_o | output | N_NODES | Sticky overflow flag per node |

## Verification
Every cycle the assertions check that valid drops after each round start, that an offered winner is really pending with a nonzero priority, and that the offer holds while idle. They also check that an accepted acknowledge clears the winner while an unaccepted one leaves flags alone, and that overflow flags only rise on a trigger into a pending node and only fall on a clear-overflow write. Which node should win does not fit in a property. Only the bench can show it, by sweeping every priority assignment of a small configuration and every enable and pending mask. The bench also covers the drain order under repeated acknowledges, the CPU level threshold at each value, and the same-cycle trigger-with-clear cases.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;

  // write commands on the software port
  typedef enum logic [1:0] {
    WCMD_CFG  = 2'd0,
    WCMD_SETP = 2'd1,
    WCMD_CLRP = 2'd2,
    WCMD_CLRO = 2'd3
  } wcmd_e;

  localparam int PRIO_MAX_W = 16;

  // winner may be taken when its number is not below the CPU level
  function automatic logic prio_admits(input logic [PRIO_MAX_W-1:0] win,
                                       input logic [PRIO_MAX_W-1:0] cur);
    return win >= cur;
  endfunction

  // strict compare: keeps the earlier (lower index) node on a tie
  function automatic logic prio_beats(input logic [PRIO_MAX_W-1:0] cand,
                                      input logic [PRIO_MAX_W-1:0] best);
    return cand > best;
  endfunction

endpackage

// File: rtl/irq_node_bank.sv
module irq_node_bank
  import irq_rt_pkg::*;
#(
  parameter int N_NODES = 8,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_NODES-1:0]        trig_i,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_node_i,
  input  logic [1:0]                wr_cmd_i,
  input  logic [PRIO_W-1:0]         wr_prio_i,
  input  logic                      wr_ena_i,
  input  logic                      ack_clr_i,
  input  logic [IDX_W-1:0]          ack_node_i,
  output logic [N_NODES-1:0]        pend_o,
  output logic [N_NODES-1:0]        ena_o,
  output logic [N_NODES*PRIO_W-1:0] prio_o,
  output logic [N_NODES-1:0]        ovf_o,
  output logic [N_NODES-1:0]        newreq_o,
  output logic [N_NODES-1:0]        ovf_hit_o
);

  for (genvar g = 0; g < N_NODES; g++) begin : g_node
    logic              sel;
    logic              sw_set;
    logic              sw_clr;
    logic              sw_clro;
    logic              sw_cfg;
    logic              ack_clr;
    logic              clr_any;
    logic              pend_q;
    logic              ovf_q;
    logic              ena_q;
    logic [PRIO_W-1:0] prio_q;

    assign sel     = wr_en_i && (wr_node_i == IDX_W'(g));
    assign sw_cfg  = sel && (wr_cmd_i == WCMD_CFG);
    assign sw_set  = sel && (wr_cmd_i == WCMD_SETP);
    assign sw_clr  = sel && (wr_cmd_i == WCMD_CLRP);
    assign sw_clro = sel && (wr_cmd_i == WCMD_CLRO);
    assign ack_clr = ack_clr_i && (ack_node_i == IDX_W'(g));
    assign clr_any = sw_clr | ack_clr;

    // a trigger into a node that stays pending is lost and flagged
    assign ovf_hit_o[g] = trig_i[g] & pend_q & ~clr_any;
    assign newreq_o[g]  = trig_i[g] & ~ovf_hit_o[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        ovf_q  <= 1'b0;
        ena_q  <= 1'b0;
        prio_q <= '0;
      end else begin
        pend_q <= trig_i[g] | sw_set | (pend_q & ~clr_any);
        ovf_q  <= (ovf_q & ~sw_clro) | ovf_hit_o[g];
        if (sw_cfg) begin
          ena_q  <= wr_ena_i;
          prio_q <= wr_prio_i;
        end
      end
    end

    assign pend_o[g]                  = pend_q;
    assign ovf_o[g]                   = ovf_q;
    assign ena_o[g]                   = ena_q;
    assign prio_o[g*PRIO_W +: PRIO_W] = prio_q;
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_rt_pkg::*;
#(
  parameter int N_NODES = 8,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [N_NODES-1:0]        cand_i,
  input  logic [N_NODES*PRIO_W-1:0] prio_i,
  output logic                      busy_o,
  output logic                      vld_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [PRIO_W-1:0]         prio_o
);

  logic [PRIO_W-1:0] best_prio;
  logic [IDX_W-1:0]  best_idx;
  logic              busy_q;
  logic              vld_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PRIO_W-1:0] prio_q;

  // linear scan, one cycle; candidates always carry a nonzero number
  always_comb begin
    best_prio = '0;
    best_idx  = '0;
    for (int i = 0; i < N_NODES; i++) begin
      if (cand_i[i] &&
          prio_beats(PRIO_MAX_W'(prio_i[i*PRIO_W +: PRIO_W]),
                     PRIO_MAX_W'(best_prio))) begin
        best_prio = prio_i[i*PRIO_W +: PRIO_W];
        best_idx  = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      idx_q  <= '0;
      prio_q <= '0;
    end else begin
      busy_q <= start_i;
      if (busy_q) begin
        vld_q  <= (best_prio != '0);
        idx_q  <= best_idx;
        prio_q <= best_prio;
      end
    end
  end

  assign busy_o = busy_q;
  assign vld_o  = vld_q & ~busy_q;
  assign idx_o  = idx_q;
  assign prio_o = prio_q;

endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router
  import irq_rt_pkg::*;
#(
  parameter int N_NODES = 8,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_NODES-1:0] trig_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_node_i,
  input  logic [1:0]         wr_cmd_i,
  input  logic [PRIO_W-1:0]  wr_prio_i,
  input  logic               wr_ena_i,
  input  logic [PRIO_W-1:0]  cpu_prio_i,
  input  logic               ack_i,
  output logic               req_valid_o,
  output logic [PRIO_W-1:0]  req_prio_o,
  output logic [IDX_W-1:0]   req_node_o,
  output logic               take_ok_o,
  output logic [N_NODES-1:0] pend_o,
  output logic [N_NODES-1:0] ovf_o
);

  logic [N_NODES-1:0]        ena;
  logic [N_NODES*PRIO_W-1:0] prio_flat;
  logic [N_NODES-1:0]        newreq;
  logic [N_NODES-1:0]        ovf_hit;
  logic [N_NODES-1:0]        elig;
  logic                      ack_take;
  logic                      arb_start;
  logic                      arb_busy;

  irq_node_bank #(
    .N_NODES (N_NODES),
    .PRIO_W  (PRIO_W),
    .IDX_W   (IDX_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig_i),
    .wr_en_i    (wr_en_i),
    .wr_node_i  (wr_node_i),
    .wr_cmd_i   (wr_cmd_i),
    .wr_prio_i  (wr_prio_i),
    .wr_ena_i   (wr_ena_i),
    .ack_clr_i  (ack_take),
    .ack_node_i (req_node_o),
    .pend_o     (pend_o),
    .ena_o      (ena),
    .prio_o     (prio_flat),
    .ovf_o      (ovf_o),
    .newreq_o   (newreq),
    .ovf_hit_o  (ovf_hit)
  );

  for (genvar g = 0; g < N_NODES; g++) begin : g_elig
    assign elig[g] = pend_o[g] & ena[g] & (|prio_flat[g*PRIO_W +: PRIO_W]);
  end

  assign take_ok_o = req_valid_o &
                     prio_admits(PRIO_MAX_W'(req_prio_o), PRIO_MAX_W'(cpu_prio_i));
  assign ack_take  = ack_i & take_ok_o;
  assign arb_start = (|newreq) | wr_en_i | ack_take;

  irq_arbiter #(
    .N_NODES (N_NODES),
    .PRIO_W  (PRIO_W),
    .IDX_W   (IDX_W)
  ) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (arb_start),
    .cand_i  (elig),
    .prio_i  (prio_flat),
    .busy_o  (arb_busy),
    .vld_o   (req_valid_o),
    .idx_o   (req_node_o),
    .prio_o  (req_prio_o)
  );

  logic unused_ok;
  assign unused_ok = |ovf_hit;

endmodule

// File: rtl/irq_prio_router_chk.sv
module irq_prio_router_chk #(
  parameter int N_NODES = 8,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_NODES-1:0] trig_i,
  input logic               wr_en_i,
  input logic [1:0]         wr_cmd_i,
  input logic               ack_i,
  input logic               req_valid_o,
  input logic [PRIO_W-1:0]  req_prio_o,
  input logic [IDX_W-1:0]   req_node_o,
  input logic               take_ok_o,
  input logic [N_NODES-1:0] pend_o,
  input logic [N_NODES-1:0] ovf_o,
  input logic               arb_start,
  input logic               arb_busy
);

  // R3
  round_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_start |=> !req_valid_o);

  // R2
  winner_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (pend_o[req_node_o] && req_prio_o != '0));

  // R4
  take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok_o |-> req_valid_o);

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && take_ok_o && !wr_en_i && trig_i == '0) |=> !pend_o[$past(req_node_o)]);

  // R5
  ack_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !take_ok_o && !wr_en_i && trig_i == '0) |=> $stable(pend_o));

  // R6
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_o & ~$past(ovf_o) & ~($past(trig_i) & $past(pend_o))) == '0));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_cmd_i == 2'd3) |=> (($past(ovf_o) & ~ovf_o) == '0));

  // R10
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_start && !arb_busy) |=>
      ($stable(req_valid_o) && $stable(req_prio_o) && $stable(req_node_o)));

endmodule

bind irq_prio_router irq_prio_router_chk #(
  .N_NODES (N_NODES),
  .PRIO_W  (PRIO_W)
) u_chk (.*);

// File: tb/sim_irq_prio_router.sv
`timescale 1ns/1ps
module sim_irq_prio_router;
  localparam int N  = 4;
  localparam int PW = 3;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  trig = '0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_node = '0;
  logic [1:0]    wr_cmd = '0;
  logic [PW-1:0] wr_prio = '0;
  logic          wr_ena = 1'b0;
  logic [PW-1:0] cpu_prio = '0;
  logic          ack = 1'b0;
  logic          req_valid;
  logic [PW-1:0] req_prio;
  logic [IW-1:0] req_node;
  logic          take_ok;
  logic [N-1:0]  pend;
  logic [N-1:0]  ovf;

  int n_chk = 0;
  int n_bad = 0;
  int mp[N];
  bit me[N];
  bit mpend[N];

  always #2 clk = ~clk;

  irq_prio_router #(.N_NODES(N), .PRIO_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .wr_en_i(wr_en),
    .wr_node_i(wr_node), .wr_cmd_i(wr_cmd), .wr_prio_i(wr_prio),
    .wr_ena_i(wr_ena), .cpu_prio_i(cpu_prio), .ack_i(ack),
    .req_valid_o(req_valid), .req_prio_o(req_prio), .req_node_o(req_node),
    .take_ok_o(take_ok), .pend_o(pend), .ovf_o(ovf)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // expected winner from the bench's own view of node state
  task automatic model(output bit v, output int idx, output int pr);
    v = 0; idx = 0; pr = 0;
    for (int i = 0; i < N; i++)
      if (mpend[i] && me[i] && mp[i] != 0 && mp[i] > pr) begin
        v = 1; idx = i; pr = mp[i];
      end
  endtask

  task automatic check_win(input string rq);
    bit v; int idx; int pr;
    model(v, idx, pr);
    chk(rq, "valid", int'(req_valid), int'(v));
    if (v) begin
      chk(rq, "node", int'(req_node), idx);
      chk(rq, "prio", int'(req_prio), pr);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input int node, input int cmd, input int pr, input bit en);
    wr_en = 1'b1; wr_node = IW'(node); wr_cmd = 2'(cmd);
    wr_prio = PW'(pr); wr_ena = en;
    @(negedge clk);
    wr_en = 1'b0;
    case (cmd)
      0: begin mp[node] = pr; me[node] = en; end
      1: mpend[node] = 1;
      2: mpend[node] = 0;
      default: ;
    endcase
  endtask

  task automatic pulse_trig(input int mask);
    trig = N'(mask);
    @(negedge clk);
    trig = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit v; int idx; int pr; int keep_p; int keep_n;
    for (int i = 0; i < N; i++) begin mp[i] = 0; me[i] = 0; mpend[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "valid after reset", int'(req_valid), 0);
    chk("R1", "pending after reset", int'(pend), 0);
    chk("R1", "overflow after reset", int'(ovf), 0);
    chk("R1", "take_ok after reset", int'(take_ok), 0);
    wr(0, 1, 0, 0);
    @(negedge clk);
    chk("R1", "pending node with prio 0 disabled", int'(req_valid), 0);
    wr(0, 0, 0, 1);
    @(negedge clk);
    chk("R1", "enabled node with prio 0", int'(req_valid), 0);

    // R2 sweep over every priority assignment with all pending
    for (int k = 0; k < N; k++) wr(k, 1, 0, 0);
    for (int code = 0; code < (1 << (PW*N)); code++) begin
      for (int k = 0; k < N; k++) wr(k, 0, (code >> (PW*k)) & ((1 << PW) - 1), 1);
      chk("R3", "valid low during round", int'(req_valid), 0);
      @(negedge clk);
      check_win("R2");
    end

    // R2 / R8 sweep of enable and pending masks with fixed priorities
    for (int em = 0; em < 16; em++)
      for (int pm = 0; pm < 16; pm++) begin
        for (int k = 0; k < N; k++) wr(k, 0, (k == 0) ? 3 : (k == 3 ? 6 : 5), em[k]);
        for (int k = 0; k < N; k++) wr(k, pm[k] ? 1 : 2, 0, 0);
        @(negedge clk);
        check_win("R8");
      end

    // R5 drain order under repeated acknowledges
    cpu_prio = '0;
    wr(0, 0, 2, 1); wr(1, 0, 6, 1); wr(2, 0, 4, 1); wr(3, 0, 6, 1);
    for (int k = 0; k < N; k++) wr(k, 1, 0, 0);
    @(negedge clk);
    for (int s = 0; s < 5; s++) begin
      check_win("R5");
      model(v, idx, pr);
      if (v) begin
        do_ack();
        mpend[idx] = 0;
        chk("R5", "acked node pending", int'(pend[idx]), 0);
        chk("R3", "valid low after ack", int'(req_valid), 0);
        @(negedge clk);
      end
    end

    // R4 threshold sweep, R5 ignored acknowledge
    for (int k = 0; k < N; k++) wr(k, 0, 0, 0);
    for (int p = 1; p < (1 << PW); p++) begin
      wr(2, 0, p, 1);
      wr(2, 1, 0, 0);
      @(negedge clk);
      for (int c = 0; c < (1 << PW); c++) begin
        cpu_prio = PW'(c);
        #1;
        chk("R4", "take_ok at cpu level", int'(take_ok), (p >= c) ? 1 : 0);
        if (p < c) begin
          do_ack();
          chk("R5", "ignored ack pending", int'(pend[2]), 1);
          chk("R5", "ignored ack valid", int'(req_valid), 1);
        end else begin
          @(negedge clk);
        end
      end
    end

    // R10 offer holds while idle
    keep_p = int'(req_prio); keep_n = int'(req_node);
    for (int s = 0; s < 4; s++) begin
      cpu_prio = PW'(s);
      @(negedge clk);
      chk("R10", "held valid", int'(req_valid), 1);
      chk("R10", "held prio", int'(req_prio), keep_p);
      chk("R10", "held node", int'(req_node), keep_n);
    end
    cpu_prio = '0;

    // R6 / R7 overflow on every node from both pending states
    for (int k = 0; k < N; k++) wr(k, 2, 0, 0);
    for (int i = 0; i < N; i++)
      for (int ip = 0; ip < 2; ip++) begin
        wr(i, ip ? 1 : 2, 0, 0);
        pulse_trig(1 << i);
        mpend[i] = 1;
        chk("R6", "pending after trigger", int'(pend[i]), 1);
        chk("R6", "overflow after trigger", int'(ovf), ip ? (1 << i) : 0);
        repeat (3) @(negedge clk);
        wr(i, 2, 0, 0);
        chk("R7", "overflow kept", int'(ovf), ip ? (1 << i) : 0);
        wr(i, 3, 0, 0);
        chk("R7", "overflow cleared by command", int'(ovf), 0);
      end

    // R9 trigger with software clear in the same cycle
    wr(0, 1, 0, 0);
    trig = 4'b0001; wr_en = 1'b1; wr_node = 2'd0; wr_cmd = 2'd2;
    @(negedge clk);
    trig = '0; wr_en = 1'b0;
    chk("R9", "pending after trigger plus clear", int'(pend[0]), 1);
    chk("R9", "overflow after trigger plus clear", int'(ovf[0]), 0);

    // R9 trigger with accepted acknowledge in the same cycle
    wr(3, 0, 7, 1);
    wr(3, 1, 0, 0);
    @(negedge clk);
    chk("R9", "winner before ack", int'(req_node), 3);
    ack = 1'b1; trig = 4'b1000;
    @(negedge clk);
    ack = 1'b0; trig = '0;
    chk("R9", "pending after trigger plus ack", int'(pend[3]), 1);
    chk("R9", "overflow after trigger plus ack", int'(ovf[3]), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule